// File: doc/BRIEF.md
# Streaming Element Packer with Endian Swap

This block sits in the data path of a memory-to-memory transfer engine. It converts the elements it reads into the elements it writes when the two sides use different element sizes. An element is 1, 2, 4 or 8 bytes wide, and every element travels right-aligned on a 64-bit bus. A job starts with a one-cycle `start` pulse, which captures the conversion settings: source size, destination size, a packing switch, an alignment mode and a swap mode. Source elements then arrive on a valid/ready stream. Destination elements leave on a second valid/ready stream, together with their size code. A source beat flagged as last ends the job. If the last beat leaves a partly gathered destination element, that element is sent out anyway.

When packing is off, each source element becomes exactly one destination element. The element is zero-padded, sign-extended, left-justified or truncated, depending on the mode and sizes. When packing is on, small source elements are gathered into a larger destination element in little-endian order, or a large source element is split into smaller ones. Last, an optional swap acts inside each destination element. It exchanges bytes within halfwords, halfwords within words, or the two words of a doubleword.

Control is a three-state machine:
- `ST_IDLE` moves to `ST_FILL` on a start with a legal configuration. On an illegal one it stays in `ST_IDLE` and raises `cfg_err`.
- `ST_FILL` accepts source beats. It moves to `ST_SEND` once a destination element is complete.
- `ST_SEND` holds the output. It stays in `ST_SEND` while split pieces remain. It returns to `ST_FILL` after an accepted output, or to `ST_IDLE` when the job's last beat has been consumed.

Top module: `dma_pack_swap`

## Requirements
- R1: After reset, `in_ready`, `out_valid`, `busy` and `cfg_err` are all 0.
- R2: A start pulse in idle latches the configuration. The size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Changes on the configuration inputs during a job have no effect, and `out_size` shows the latched destination size.
- R3: With packing off (`cfg_pack` = 0), alignment code 0 or 3, and a source smaller than the destination, the output is the source element's low bytes. All bits above the source size are zero, and no bus bit above the destination size is ever set.
- R4: Alignment code 1 with a smaller source fills the destination bits above the source with the source's top bit.
- R5: Alignment code 2 with a smaller source places the source element in the upper bytes of the destination element and leaves the low bytes zero.
- R6: With packing off and a destination not larger than the source, the output is the source's low destination-size bytes, whatever the alignment code.
- R7: A start with alignment code 1 and a source size not smaller than the destination size sets `cfg_err`, leaves the block idle, and keeps `in_ready` low. The next legal start clears `cfg_err`.
- R8: With packing on and a smaller source, consecutive source elements are gathered into one destination element. The first element lands in the lowest bytes.
- R9: A last beat that arrives during gathering emits the partial element with its unfilled bytes zero. After the job's final output is accepted, `busy` returns to 0.
- R10: With packing on and a larger source, each source element is emitted as several destination elements, lowest bytes first.
- R11: Swap code 1 exchanges the bytes of each halfword and acts only if the destination is 2 bytes or wider. Swap code 2 exchanges the halfwords of each word and needs a destination of at least 4 bytes. Swap code 3 exchanges the two words and needs an 8-byte destination. Code 0 and non-applicable codes leave the data unchanged.
- R12: While `out_valid` is high and `out_ready` is low, `out_data` stays constant and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a job; sampled in idle |
| cfg_src_size | input | 2 | Source element size code |
| cfg_dst_size | input | 2 | Destination element size code |
| cfg_pack | input | 1 | Gather/split enable |
| cfg_align | input | 2 | 0/3 zero pad, 1 sign extend, 2 left-justify |
| cfg_swap | input | 2 | 0 none, 1 bytes, 2 halfwords, 3 words |
| in_valid | input | 1 | Source element valid |
| in_ready | output | 1 | Source element accepted when high with valid |
| in_data | input | 64 | Source element, right-aligned |
| in_last | input | 1 | Marks the final source element of the job |
| out_valid | output | 1 | Destination element valid |
| out_ready | input | 1 | Downstream accepts the destination element |
| out_data | output | 64 | Destination element, right-aligned |
| out_size | output | 2 | Size code of the destination element |
| busy | output | 1 | A job is in progress |
| cfg_err | output | 1 | Last start was refused for an illegal configuration |

## Verification
Some properties are checked on every cycle. The output must hold its value under backpressure, and input and output handshakes must never be open at once. No bit above the latched destination size may be set, the reported size must not change during a job, and a refused start must leave the block idle. The value conversions can only be shown by directed scenarios: padding, sign fill, left placement, truncation, gather order, partial flush, split order and each swap granule. Those scenarios also show that configuration changes made mid-job are ignored.

// File: rtl/dmapk_pkg.sv
package dmapk_pkg;
    localparam int DW     = 64;
    localparam int SZ_W   = 2;
    localparam int CNT_W  = 4;

    typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_WD = 2'd2, SZ_D = 2'd3} size_e;
    typedef enum logic [1:0] {AL_ZERO = 2'd0, AL_SIGN = 2'd1, AL_LEFT = 2'd2, AL_ZERO2 = 2'd3} align_e;
    typedef enum logic [1:0] {SW_NONE = 2'd0, SW_BYTE = 2'd1, SW_HALF = 2'd2, SW_WORD = 2'd3} swap_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_FILL = 2'd1, ST_SEND = 2'd2} state_e;

    typedef struct packed {
        size_e  src;
        size_e  dst;
        logic   pack;
        align_e align;
        swap_e  swap;
    } cfg_t;

    function automatic int size_bits(size_e s);
        return 8 << int'(s);
    endfunction

    function automatic logic [DW-1:0] size_mask(size_e s);
        logic [DW-1:0] ones;
        ones = '1;
        return ones >> (DW - size_bits(s));
    endfunction
endpackage

// File: rtl/dmapk_align.sv
module dmapk_align
    import dmapk_pkg::*;
(
    input  cfg_t          cfg,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] low;
    logic          top_bit;

    always_comb begin
        low     = din & size_mask(cfg.src);
        top_bit = din[size_bits(cfg.src) - 1];
        if (cfg.src < cfg.dst) begin
            unique case (cfg.align)
                AL_SIGN:  dout = low | (top_bit ? (size_mask(cfg.dst) & ~size_mask(cfg.src)) : '0);
                AL_LEFT:  dout = low << (size_bits(cfg.dst) - size_bits(cfg.src));
                default:  dout = low;
            endcase
        end else begin
            dout = din & size_mask(cfg.dst);
        end
    end
endmodule

// File: rtl/dmapk_swap.sv
module dmapk_swap
    import dmapk_pkg::*;
(
    input  size_e         dst,
    input  swap_e         mode,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [2:0][DW-1:0] pair_sw;

    for (genvar g = 0; g < 3; g++) begin : g_gran
        localparam int GB = 8 << g;
        for (genvar k = 0; k < DW / (2 * GB); k++) begin : g_pair
            assign pair_sw[g][2*GB*k +: GB]      = din[2*GB*k + GB +: GB];
            assign pair_sw[g][2*GB*k + GB +: GB] = din[2*GB*k +: GB];
        end
    end

    always_comb begin
        unique case (mode)
            SW_BYTE: dout = (dst != SZ_B)  ? pair_sw[0] : din;
            SW_HALF: dout = (dst >= SZ_WD) ? pair_sw[1] : din;
            SW_WORD: dout = (dst == SZ_D)  ? pair_sw[2] : din;
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/dma_pack_swap.sv
module dma_pack_swap
    import dmapk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [SZ_W-1:0] cfg_src_size,
    input  logic [SZ_W-1:0] cfg_dst_size,
    input  logic            cfg_pack,
    input  logic [1:0]      cfg_align,
    input  logic [1:0]      cfg_swap,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [DW-1:0]   in_data,
    input  logic            in_last,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [DW-1:0]   out_data,
    output logic [SZ_W-1:0] out_size,
    output logic            busy,
    output logic            cfg_err
);
    state_e            st, st_nxt;
    cfg_t              cfg_in, cfg_q;
    logic [DW-1:0]     acc, acc_nxt, split_src, out_q;
    logic [DW-1:0]     piece_in, split_piece, aligned, sw_in, sw_out;
    logic [CNT_W-1:0]  cnt, ratio_m1;
    logic [1:0]        rlog;
    logic              last_q, cfg_bad, gather, split, fill_done, more_pieces, err_q;

    assign cfg_in  = '{src: size_e'(cfg_src_size), dst: size_e'(cfg_dst_size), pack: cfg_pack,
                       align: align_e'(cfg_align), swap: swap_e'(cfg_swap)};
    assign cfg_bad = (cfg_in.align == AL_SIGN) && (cfg_in.src >= cfg_in.dst);

    assign gather      = cfg_q.pack && (cfg_q.src < cfg_q.dst);
    assign split       = cfg_q.pack && (cfg_q.src > cfg_q.dst);
    assign rlog        = gather ? (2'(cfg_q.dst) - 2'(cfg_q.src)) : (2'(cfg_q.src) - 2'(cfg_q.dst));
    assign ratio_m1    = (CNT_W'(1) << rlog) - CNT_W'(1);
    assign fill_done   = !gather || (cnt == ratio_m1) || in_last;
    assign more_pieces = split && (cnt != ratio_m1);

    assign piece_in    = in_data & size_mask(cfg_q.src);
    assign acc_nxt     = acc | (piece_in << (int'(cnt) * size_bits(cfg_q.src)));
    assign split_piece = (split_src >> ((int'(cnt) + 1) * size_bits(cfg_q.dst))) & size_mask(cfg_q.dst);

    dmapk_align u_align (.cfg(cfg_q), .din(in_data), .dout(aligned));

    always_comb begin
        if (st == ST_SEND)  sw_in = split_piece;
        else if (gather)    sw_in = acc_nxt;
        else if (split)     sw_in = in_data & size_mask(cfg_q.dst);
        else                sw_in = aligned;
    end

    dmapk_swap u_swap (.dst(cfg_q.dst), .mode(cfg_q.swap), .din(sw_in), .dout(sw_out));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (start && !cfg_bad)            st_nxt = ST_FILL;
            ST_FILL: if (in_valid && fill_done)        st_nxt = ST_SEND;
            ST_SEND: if (out_ready && !more_pieces)    st_nxt = last_q ? ST_IDLE : ST_FILL;
            default:                                   st_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = (st == ST_FILL);
        out_valid = (st == ST_SEND);
        busy      = (st != ST_IDLE);
        out_data  = out_q;
        out_size  = cfg_q.dst;
        cfg_err   = err_q;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            acc       <= '0;
            split_src <= '0;
            out_q     <= '0;
            cnt       <= '0;
            last_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    if (cfg_bad) begin
                        err_q <= 1'b1;
                    end else begin
                        err_q <= 1'b0;
                        cfg_q <= cfg_in;
                        acc   <= '0;
                        cnt   <= '0;
                    end
                end
                ST_FILL: if (in_valid) begin
                    last_q <= in_last;
                    if (!fill_done) begin
                        acc <= acc_nxt;
                        cnt <= cnt + CNT_W'(1);
                    end else begin
                        out_q <= sw_out;
                        acc   <= '0;
                        cnt   <= '0;
                        if (split) split_src <= piece_in;
                    end
                end
                ST_SEND: if (out_ready && more_pieces) begin
                    cnt   <= cnt + CNT_W'(1);
                    out_q <= sw_out;
                end
                default: ;
            endcase
        end
    end

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_one_side_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    p_no_high_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & ~size_mask(size_e'(out_size))) == '0));

    p_refused_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> !busy);

    p_size_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(out_size));
endmodule

// File: tb/dma_pack_swap_bench.sv
`timescale 1ns/1ps
module dma_pack_swap_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cfg_src_size = '0, cfg_dst_size = '0, cfg_align = '0, cfg_swap = '0;
    logic        cfg_pack = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
    logic [63:0] in_data = '0;
    logic        in_ready, out_valid, busy, cfg_err;
    logic [63:0] out_data;
    logic [1:0]  out_size;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    dma_pack_swap u_dma_pack_swap (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_src_size(cfg_src_size), .cfg_dst_size(cfg_dst_size), .cfg_pack(cfg_pack),
        .cfg_align(cfg_align), .cfg_swap(cfg_swap),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_size(out_size), .busy(busy), .cfg_err(cfg_err));

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_start(logic [1:0] s, logic [1:0] d, logic p, logic [1:0] a, logic [1:0] w);
        @(negedge clk);
        cfg_src_size = s; cfg_dst_size = d; cfg_pack = p; cfg_align = a; cfg_swap = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: scramble settings after the start; the running job must ignore them
        cfg_src_size = ~s; cfg_dst_size = ~d; cfg_pack = ~p; cfg_align = a ^ 2'd2; cfg_swap = ~w;
    endtask

    task automatic push(logic [63:0] data, logic last);
        in_valid = 1'b1; in_data = data; in_last = last;
        for (int i = 0; i < 50 && !in_ready; i++) @(negedge clk);
        if (!in_ready) check("push timeout", 64'd0, 64'd1);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    endtask

    task automatic pull(logic [63:0] exp, string tag);
        out_ready = 1'b1;
        for (int i = 0; i < 50 && !out_valid; i++) @(negedge clk);
        check(tag, out_data, exp);
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 in_ready", 64'(in_ready), 64'd0);
        check("R1 out_valid", 64'(out_valid), 64'd0);
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 cfg_err", 64'(cfg_err), 64'd0);
    endtask

    task automatic t_zero_pad();
        do_start(2'd0, 2'd2, 1'b0, 2'd0, 2'd0);
        check("R2 out_size", 64'(out_size), 64'd2);
        push(64'hAAAA_AAAA_AAAA_AAF3, 1'b1);
        pull(64'h0000_0000_0000_00F3, "R3 zero pad");
        check("R9 idle after last", 64'(busy), 64'd0);
    endtask

    task automatic t_sign();
        do_start(2'd1, 2'd3, 1'b0, 2'd1, 2'd0);
        push(64'h1234_5678_9ABC_8001, 1'b0);
        pull(64'hFFFF_FFFF_FFFF_8001, "R4 negative");
        push(64'hFFFF_FFFF_FFFF_7001, 1'b1);
        pull(64'h0000_0000_0000_7001, "R4 positive");
    endtask

    task automatic t_left();
        do_start(2'd0, 2'd2, 1'b0, 2'd2, 2'd0);
        push(64'h0000_0000_0000_775A, 1'b1);
        pull(64'h0000_0000_5A00_0000, "R5 left justify");
    endtask

    task automatic t_trunc();
        do_start(2'd3, 2'd1, 1'b0, 2'd2, 2'd0);
        push(64'h1122_3344_5566_7788, 1'b1);
        pull(64'h0000_0000_0000_7788, "R6 truncate");
    endtask

    task automatic t_cfg_err();
        do_start(2'd2, 2'd1, 1'b0, 2'd1, 2'd0);
        check("R7 err set", 64'(cfg_err), 64'd1);
        check("R7 stays idle", 64'(busy), 64'd0);
        in_valid = 1'b1; in_data = 64'h55;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R7 no accept", 64'(in_ready), 64'd0);
        end
        in_valid = 1'b0;
        do_start(2'd2, 2'd2, 1'b0, 2'd1, 2'd0);
        check("R7 equal sizes refused", 64'(cfg_err), 64'd1);
        do_start(2'd2, 2'd2, 1'b0, 2'd0, 2'd0);
        check("R7 err cleared", 64'(cfg_err), 64'd0);
        push(64'h0BAD_CAFE, 1'b1);
        pull(64'h0BAD_CAFE, "R6 equal size pass");
    endtask

    task automatic t_gather();
        do_start(2'd0, 2'd2, 1'b1, 2'd2, 2'd0);
        push(64'hFF11, 1'b0);
        push(64'hFF22, 1'b0);
        push(64'hFF33, 1'b0);
        push(64'hFF44, 1'b0);
        pull(64'h4433_2211, "R8 R2 gather");
        push(64'h55, 1'b0);
        push(64'h66, 1'b0);
        push(64'h77, 1'b0);
        push(64'h88, 1'b1);
        pull(64'h8877_6655, "R8 second word");
    endtask

    task automatic t_flush();
        do_start(2'd0, 2'd3, 1'b1, 2'd0, 2'd0);
        push(64'hA1, 1'b0);
        push(64'hB2, 1'b0);
        push(64'hC3, 1'b1);
        pull(64'h0000_0000_00C3_B2A1, "R9 partial flush");
        check("R9 busy low", 64'(busy), 64'd0);
    endtask

    task automatic t_split();
        do_start(2'd3, 2'd1, 1'b1, 2'd0, 2'd0);
        push(64'h1122_3344_5566_7788, 1'b1);
        pull(64'h7788, "R10 piece 0");
        pull(64'h5566, "R10 piece 1");
        pull(64'h3344, "R10 piece 2");
        pull(64'h1122, "R10 piece 3");
        check("R10 done", 64'(busy), 64'd0);
    endtask

    task automatic t_swaps();
        do_start(2'd2, 2'd2, 1'b0, 2'd0, 2'd1);
        push(64'h1122_3344, 1'b1);
        pull(64'h2211_4433, "R11 byte swap");
        do_start(2'd2, 2'd2, 1'b0, 2'd0, 2'd2);
        push(64'h1122_3344, 1'b1);
        pull(64'h3344_1122, "R11 half swap");
        do_start(2'd2, 2'd2, 1'b0, 2'd0, 2'd3);
        push(64'h1122_3344, 1'b1);
        pull(64'h1122_3344, "R11 word swap n/a");
        do_start(2'd3, 2'd3, 1'b0, 2'd0, 2'd3);
        push(64'h1122_3344_5566_7788, 1'b1);
        pull(64'h5566_7788_1122_3344, "R11 word swap");
        do_start(2'd0, 2'd0, 1'b0, 2'd0, 2'd1);
        push(64'h9A, 1'b1);
        pull(64'h9A, "R11 byte dest n/a");
    endtask

    task automatic t_backpressure();
        logic [63:0] first;
        do_start(2'd1, 2'd1, 1'b0, 2'd0, 2'd0);
        push(64'hBEEF, 1'b1);
        first = out_data;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R12 valid held", 64'(out_valid), 64'd1);
            check("R12 data held", out_data, first);
            check("R12 input closed", 64'(in_ready), 64'd0);
        end
        pull(64'hBEEF, "R12 value");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_pad();
        t_sign();
        t_left();
        t_trunc();
        t_cfg_err();
        t_gather();
        t_flush();
        t_split();
        t_swaps();
        t_backpressure();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule